// File: doc/BRIEF.md
# Dual-Channel Serial ADC Reader

This block is the host side of a link to a dual-channel 12-bit successive-approximation converter. The converter has an active-low chip select, a serial clock input and one data output per channel. When the block sees a start request, it pulls chip select low, and that low edge also starts the conversion. The block then derives the serial clock from its own system clock and captures both data lines in parallel. Once the frame is complete it raises chip select again. Each channel sends three leading bits, then the 12-bit result with the most significant bit first, then one trailing bit. The block removes the leading bits, checks that they are zero, and presents both results together with a one-cycle valid strobe.

The block holds a quiet interval after every frame before it accepts the next start, so the converter's minimum recovery time is always met. Three parameters set the timing, all in system clock cycles: the half period of the serial clock, the setup delay from chip select to the first clock edge, and the quiet interval. A busy output tells the requester when a new start will be accepted.

Top module: `dual_adc_reader`

## Requirements
- R1: After synchronous reset, chip select and the serial clock are high, busy and valid are low, both results are zero and the framing error flag is clear.
- R2: A start request sampled while busy is low drives chip select low and busy high at the next clock edge. A start request sampled while busy is high is ignored and produces no extra frame or result.
- R3: The serial clock stays high whenever chip select is high. Within a frame, each low phase of the serial clock lasts exactly HALF_DIV system cycles, and the data lines are sampled on the rising edge of the serial clock.
- R4: Chip select is low for at least SETUP_CYC system cycles before the first falling edge of the serial clock.
- R5: A frame has exactly 16 serial clock cycles. Frame bit k (k = 0..15) is the value on a data line during the low phase that follows falling edge k+1. Chip select rises at the same clock edge as the 16th rising edge.
- R6: Frame bits 3..14 form the 12-bit result, with bit 3 as the most significant bit. Channel A comes from the first data input and channel B from the second, both taken from the same edges. Frame bit 15 has no effect on either result.
- R7: Valid is high for exactly one system cycle, one cycle after chip select rises. At that point both results update together, and they hold their values until the next valid pulse.
- R8: If any of frame bits 0..2 is one on either channel, the framing error flag rises together with that frame's valid pulse, and the frame's results are still delivered. The flag stays set until reset.
- R9: After chip select rises, busy stays high for exactly QUIET_CYC system cycles and chip select stays high throughout. A start request during this interval is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion frame |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_a_i | input | 1 | Serial data from channel A |
| sdata_b_i | input | 1 | Serial data from channel B |
| busy_o | output | 1 | Frame or quiet interval in progress |
| valid_o | output | 1 | One-cycle strobe: new results present |
| result_a_o | output | DATA_W | Channel A result |
| result_b_o | output | DATA_W | Channel B result |
| frame_err_o | output | 1 | Sticky flag: a leading bit was nonzero |

## Verification
The assertions check the link protocol on every cycle:
- the serial clock idles high outside a frame;
- every low phase has the programmed length;
- the setup margin and the quiet gap are respected;
- each frame has exactly sixteen rising edges;
- the valid pulse lasts one cycle and follows the rise of chip select;
- the results hold steady between pulses;
- the error flag is sticky.

The bench scenarios cover what the assertions cannot see. They check that the captured bits land in the right positions on each channel, that the trailing bit has no effect, and that a framing error is raised by a nonzero leading bit on only one channel. They also check that start requests made mid-frame or during the quiet gap are ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_QUIET = 2'd3
  } rd_state_e;

endpackage

// File: rtl/adc_rd_sclk_gen.sv
// Serial clock generator: idles high, toggles every HALF_DIV cycles while run_i.
module adc_rd_sclk_gen #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [HW-1:0] hcnt;
  logic          expire;

  assign expire = (hcnt == HW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      hcnt   <= '0;
      sclk_o <= 1'b1;
    end else if (expire) begin
      hcnt   <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      hcnt   <= hcnt + HW'(1);
    end
  end

  // Marks the cycle whose closing edge drives the serial clock high.
  assign rise_o = run_i & expire & ~sclk_o;

endmodule

// File: rtl/adc_rd_ctrl.sv
// Frame sequencer: setup, shift, quiet phases and chip select.
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int QUIET_CYC  = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rise_i,
  output logic run_o,
  output logic shift_o,
  output logic done_o,
  output logic cs_n_o,
  output logic busy_o
);
  localparam int CMAX = (SETUP_CYC > QUIET_CYC) ? SETUP_CYC : QUIET_CYC;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;
  localparam int BW   = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  rd_state_e     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitcnt;
  logic          last;

  assign last    = (bitcnt == BW'(FRAME_BITS - 1));
  assign run_o   = (state == ST_SHIFT);
  // The final rising edge carries the trailing bit, which is never stored.
  assign shift_o = run_o & rise_i & ~last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitcnt <= '0;
      cs_n_o <= 1'b1;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state  <= ST_SETUP;
            cnt    <= '0;
            cs_n_o <= 1'b0;
            busy_o <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt == CW'(SETUP_CYC - 1)) begin
            state  <= ST_SHIFT;
            cnt    <= '0;
            bitcnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_SHIFT: begin
          if (rise_i) begin
            if (last) begin
              state  <= ST_QUIET;
              cs_n_o <= 1'b1;
              done_o <= 1'b1;
              cnt    <= '0;
            end else begin
              bitcnt <= bitcnt + BW'(1);
            end
          end
        end
        ST_QUIET: begin
          if (cnt == CW'(QUIET_CYC - 1)) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_chan.sv
// One channel: shift register plus output register and leading-bit check.
module adc_rd_chan #(
  parameter int LEAD_W = 3,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic              load_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              lead_bad_o
);
  localparam int SW = LEAD_W + DATA_W;

  logic [SW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      result_o <= '0;
    end else begin
      if (shift_i) sh <= {sh[SW-2:0], sdata_i};
      if (load_i)  result_o <= sh[DATA_W-1:0];
    end
  end

  assign lead_bad_o = |sh[SW-1 -: LEAD_W];

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DATA_W    = 12,
  parameter int LEAD_W    = 3,
  parameter int HALF_DIV  = 3,
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              sdata_a_i,
  input  logic              sdata_b_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_a_o,
  output logic [DATA_W-1:0] result_b_o,
  output logic              frame_err_o
);
  localparam int FRAME_BITS = LEAD_W + DATA_W + 1;
  localparam int NCH        = 2;

  logic run, rise, shift, done;
  logic [NCH-1:0]             sdata;
  logic [NCH-1:0]             lead_bad;
  logic [NCH-1:0][DATA_W-1:0] res;

  assign sdata = {sdata_b_i, sdata_a_i};

  adc_rd_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .QUIET_CYC (QUIET_CYC),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .rise_i (rise),
    .run_o  (run),
    .shift_o(shift),
    .done_o (done),
    .cs_n_o (cs_n_o),
    .busy_o (busy_o)
  );

  adc_rd_sclk_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_sclk (
    .clk   (clk),
    .rst   (rst),
    .run_i (run),
    .sclk_o(sclk_o),
    .rise_o(rise)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    adc_rd_chan #(
      .LEAD_W(LEAD_W),
      .DATA_W(DATA_W)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .shift_i   (shift),
      .load_i    (done),
      .sdata_i   (sdata[c]),
      .result_o  (res[c]),
      .lead_bad_o(lead_bad[c])
    );
  end

  assign result_a_o = res[0];
  assign result_b_o = res[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= done;
      frame_err_o <= frame_err_o | (done & (|lead_bad));
    end
  end

endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk #(
  parameter int DATA_W     = 12,
  parameter int HALF_DIV   = 3,
  parameter int SETUP_CYC  = 2,
  parameter int QUIET_CYC  = 4,
  parameter int FRAME_BITS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_a_o,
  input logic [DATA_W-1:0] result_b_o,
  input logic              frame_err_o
);
  logic [15:0] low_run, cs_low_run, cs_high_run;
  logic [7:0]  rise_cnt;
  logic        sclk_d, seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run     <= '0;
      cs_low_run  <= '0;
      cs_high_run <= '0;
      rise_cnt    <= '0;
      sclk_d      <= 1'b1;
      seen_rise   <= 1'b0;
    end else begin
      sclk_d      <= sclk_o;
      low_run     <= sclk_o ? 16'd0 : ((low_run == 16'hFFFF) ? low_run : low_run + 16'd1);
      cs_low_run  <= cs_n_o ? 16'd0 : ((cs_low_run == 16'hFFFF) ? cs_low_run : cs_low_run + 16'd1);
      cs_high_run <= !cs_n_o ? 16'd0 : ((cs_high_run == 16'hFFFF) ? cs_high_run : cs_high_run + 16'd1);
      if (cs_n_o)                rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 8'd1;
      if (cs_n_o && cs_low_run != 16'd0) seen_rise <= 1'b1;
    end
  end

  a_r2_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o);

  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  a_r3_low_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (low_run == 16'(HALF_DIV)));

  a_r4_setup: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk_o) && !cs_n_o) |-> (cs_low_run >= 16'(SETUP_CYC)));

  a_r5_frame_len: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> ((rise_cnt == 8'(FRAME_BITS - 1)) && $rose(sclk_o)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r7_valid_after_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |=> valid_o);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(result_a_o) && $stable(result_b_o)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> frame_err_o);

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n_o) && seen_rise) |-> (cs_high_run >= 16'(QUIET_CYC)));

endmodule

bind dual_adc_reader dual_adc_reader_chk #(
  .DATA_W    (DATA_W),
  .HALF_DIV  (HALF_DIV),
  .SETUP_CYC (SETUP_CYC),
  .QUIET_CYC (QUIET_CYC),
  .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .result_a_o (result_a_o),
  .result_b_o (result_b_o),
  .frame_err_o(frame_err_o)
);

// File: tb/dual_adc_reader_test.sv
module dual_adc_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HD = 2;
  localparam int SU = 3;
  localparam int QU = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic sd_a = 1'b1, sd_b = 1'b1;
  logic cs_n_o, sclk_o, busy_o, valid_o, frame_err_o;
  logic [11:0] result_a_o, result_b_o;

  int checks = 0, fails = 0;
  logic [24:0] exp_q[$];
  logic exp_err = 1'b0;
  logic [15:0] fa = 16'hFFFF, fb = 16'hFFFF;
  int idx = 0;
  logic prev_valid = 1'b0;
  logic [11:0] held_a = '0, held_b = '0;

  dual_adc_reader #(.DATA_W(12), .LEAD_W(3), .HALF_DIV(HD), .SETUP_CYC(SU), .QUIET_CYC(QU)) uut (
    .clk(clk), .rst(rst), .start_i(start), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .sdata_a_i(sd_a), .sdata_b_i(sd_b), .busy_o(busy_o), .valid_o(valid_o),
    .result_a_o(result_a_o), .result_b_o(result_b_o), .frame_err_o(frame_err_o));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // Converter model: frame bit k appears after serial clock fall k+1.
  always @(negedge cs_n_o) idx = 0;
  always @(negedge sclk_o) if (!cs_n_o && idx < 16) begin
    sd_a = fa[15-idx];
    sd_b = fb[15-idx];
    idx++;
  end
  always @(posedge cs_n_o) begin sd_a = 1'b1; sd_b = 1'b1; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        chk(!prev_valid, "R7", "valid longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected valid", 1, 0);
        end else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          chk(result_a_o == e[23:12], "R6", "channel A result", result_a_o, e[23:12]);
          chk(result_b_o == e[11:0], "R6", "channel B result", result_b_o, e[11:0]);
          chk(frame_err_o == e[24], "R8", "framing error flag", frame_err_o, e[24]);
        end
        held_a = result_a_o;
        held_b = result_b_o;
      end else if (result_a_o != held_a || result_b_o != held_b) begin
        chk(1'b0, "R7", "results changed without valid", result_a_o, held_a);
      end
      prev_valid = valid_o;
    end
  end

  task automatic run_frame(input logic [2:0] la, input logic [11:0] ra,
                           input logic [2:0] lb, input logic [11:0] rb,
                           input logic trail, input bit poke_shift, input bit poke_quiet);
    int n, rises, low, badlow, q;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    fa = {la, ra, trail};
    fb = {lb, rb, trail};
    if (la != 3'd0 || lb != 3'd0) exp_err = 1'b1;
    exp_q.push_back({exp_err, ra, rb});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n_o && busy_o, "R2", "start lowers chip select, raises busy", {cs_n_o, busy_o}, 2'b01);
    n = 0;
    while (sclk_o && !cs_n_o && n < 1000) begin n++; @(negedge clk); end
    chk(n >= SU, "R4", "setup cycles before first fall", n, SU);
    rises = 0; low = 0; badlow = 0;
    forever begin
      if (!sclk_o) low++;
      else if (low != 0) begin
        if (low != HD) badlow++;
        rises++;
        low = 0;
      end
      start = (poke_shift && rises == 8);
      if (cs_n_o || rises > 40) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(rises == 16, "R5", "serial clock rises per frame", rises, 16);
    chk(badlow == 0, "R3", "low phases of wrong length", badlow, 0);
    q = 0;
    while (busy_o && q < 1000) begin
      if (!cs_n_o) chk(1'b0, "R9", "chip select low during quiet", 0, 1);
      start = (poke_quiet && q == 1);
      q++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(q == QU, "R9", "quiet cycles with busy high", q, QU);
    if (poke_shift || poke_quiet) begin
      for (int i = 0; i < 6; i++) begin
        chk(cs_n_o && !busy_o, poke_quiet ? "R9" : "R2", "ignored start began a frame",
            {cs_n_o, busy_o}, 2'b10);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1, "R1", "chip select after reset", cs_n_o, 1);
    chk(sclk_o == 1'b1, "R1", "serial clock after reset", sclk_o, 1);
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(valid_o == 1'b0, "R1", "valid after reset", valid_o, 0);
    chk(result_a_o == 12'd0 && result_b_o == 12'd0, "R1", "results after reset", result_a_o, 0);
    chk(frame_err_o == 1'b0, "R1", "error flag after reset", frame_err_o, 0);

    run_frame(3'd0, 12'hABC, 3'd0, 12'h123, 1'b0, 1'b0, 1'b0);
    run_frame(3'd0, 12'hFFF, 3'd0, 12'h000, 1'b0, 1'b1, 1'b0);  // R2 start mid-frame
    run_frame(3'd0, 12'h800, 3'd0, 12'h001, 1'b1, 1'b0, 1'b1);  // R6 trailing one, R9 start in quiet
    run_frame(3'd0, 12'h5A5, 3'b010, 12'hC3C, 1'b0, 1'b0, 1'b0); // R8 error on B only
    run_frame(3'd0, 12'h001, 3'd0, 12'h7FE, 1'b0, 1'b0, 1'b0);  // R8 flag stays set
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "frames without a result", exp_q.size(), 0);
    chk(frame_err_o == 1'b1, "R8", "sticky flag at end", frame_err_o, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule